// File: doc/BRIEF.md
# Iterative Signed/Unsigned Integer Divider

This unit divides a dividend by a divisor over many clock cycles. It works in two's-complement or plain binary arithmetic. It returns a quotient and, when extended mode is selected, a remainder as well. Each result carries a write strobe and a destination register index. A divide by zero is illegal in both arithmetic modes. In signed mode the most negative dividend divided by minus one is also illegal. An illegal divide raises the overflow flag, writes nothing, and leaves the result outputs holding their earlier values.

A request enters through a valid/ready handshake. The unit takes the request when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` stays low while a divide is in progress, and `in_valid` is ignored during that time. The caller applies back-pressure only by holding its request until `in_ready` is high. The result side has no back-pressure: `done` and the write strobes are one-cycle pulses that the register file must take when they occur.

Inside, the unit takes the magnitudes of both operands. It runs one restoring shift-subtract step per cycle, then applies the result signs in a final fix-up cycle.

Top module: `int_divider`

## Requirements
- R1: In unsigned mode (`is_signed`=0) a legal divide returns `quotient` = floor(dividend/divisor) and `remainder` = dividend − quotient×divisor.
- R2: In signed mode (`is_signed`=1) the quotient is truncated toward zero and the remainder has the sign of the dividend (for example −7/2 gives −3 rem −1, and 7/−2 gives −3 rem 1).
- R3: In signed mode, a divisor of 0, or a divisor of 0xFFFFFFFF with a dividend of 0x80000000, is illegal. The unit then pulses `done` with `ovf`=1 and with `wr_en_q`=`wr_en_r`=0.
- R4: In unsigned mode only a zero divisor is illegal. 0x80000000 / 0xFFFFFFFF is legal and gives quotient 0, remainder 0x80000000.
- R5: A legal divide pulses `wr_en_q` with `done`, sets `q_idx` to the request's `dst_idx`, and clears `ovf`. `ovf` changes only in a `done` cycle and holds between completions.
- R6: With `ext_mode`=1, a legal divide also pulses `wr_en_r` and sets `r_idx` = `dst_idx`+1 modulo 2^IDXW. With `ext_mode`=0, `wr_en_r` stays 0.
- R7: `in_ready` is 1 when the unit is idle. It drops in the cycle after an accepting edge and rises again in the cycle in which `done` is high.
- R8: `in_valid` asserted while `in_ready` is 0 is ignored. The running result is unchanged and no extra `done` follows.
- R9: `done` is a single-cycle pulse. It rises W+1 rising edges after the accepting edge for a legal divide, and 1 edge after for an illegal one.
- R10: After reset, `in_ready`=1 and `done`, `wr_en_q`, `wr_en_r`, `ovf`, `quotient` and `remainder` are all 0.
- R11: An illegal divide leaves `quotient` and `remainder` at the values of the last legal divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit idle and able to take a request |
| dividend | input | W | Dividend |
| divisor | input | W | Divisor |
| is_signed | input | 1 | 1 = two's-complement divide |
| ext_mode | input | 1 | 1 = also deliver the remainder |
| dst_idx | input | IDXW | Destination register index for the quotient |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Quotient of the last legal divide |
| remainder | output | W | Remainder of the last legal divide |
| wr_en_q | output | 1 | Write strobe for the quotient |
| wr_en_r | output | 1 | Write strobe for the remainder |
| q_idx | output | IDXW | Quotient destination index |
| r_idx | output | IDXW | Remainder destination index |
| ovf | output | 1 | Overflow flag of the last completed divide |

## Verification
A wrong iteration count or a damaged partial remainder appears as a wrong quotient or remainder at the next `done` pulse. A wrong count also shifts `done` away from its fixed latency, so the fault shows within one divide of about W+1 cycles. A bad sign-handling or illegal-detect path shows in the directed sign and overflow cases: `ovf`, the write strobes, or the held result values disagree in that same completion cycle. A handshake fault shows as `in_ready` high too early, or as an extra `done` a few cycles after a poked request.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_operand_prep.sv
// Turns the raw operands into magnitudes, result signs and an illegal flag.
module div_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  input  logic         sgn,
  output logic [W-1:0] num_mag,
  output logic [W-1:0] den_mag,
  output logic         neg_quo,
  output logic         neg_rem,
  output logic         illegal
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic num_neg, den_neg;

  always_comb begin
    num_neg = sgn & num[W-1];
    den_neg = sgn & den[W-1];
    num_mag = num_neg ? (~num + 1'b1) : num;
    den_mag = den_neg ? (~den + 1'b1) : den;
    neg_quo = num_neg ^ den_neg;
    neg_rem = num_neg;
    illegal = (den == '0) | (sgn & (den == ALL_ONES) & (num == MOST_NEG));
  end
endmodule

// File: rtl/div_step.sv
// One restoring shift-subtract iteration on unsigned magnitudes.
module div_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] quo_in,
  input  logic [W-1:0] den_mag,
  output logic [W-1:0] rem_out,
  output logic [W-1:0] quo_out
);
  logic [W:0] trial;
  logic [W:0] diff;
  logic       take;

  always_comb begin
    trial   = {rem_in, quo_in[W-1]};
    diff    = trial - {1'b0, den_mag};
    take    = ~diff[W];
    rem_out = take ? diff[W-1:0] : trial[W-1:0];
    quo_out = {quo_in[W-2:0], take};
  end
endmodule

// File: rtl/int_divider.sv
module int_divider #(
  parameter int W    = 32,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W-1:0]    dividend,
  input  logic [W-1:0]    divisor,
  input  logic            is_signed,
  input  logic            ext_mode,
  input  logic [IDXW-1:0] dst_idx,
  output logic            done,
  output logic [W-1:0]    quotient,
  output logic [W-1:0]    remainder,
  output logic            wr_en_q,
  output logic            wr_en_r,
  output logic [IDXW-1:0] q_idx,
  output logic [IDXW-1:0] r_idx,
  output logic            ovf
);
  import div_pkg::*;

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_state_e    state;
  logic [CW-1:0] iter_cnt;
  logic [W-1:0]  part_rem, part_quo, den_q;
  logic          neg_quo_q, neg_rem_q, illegal_q, ext_q;
  logic [IDXW-1:0] idx_q;

  logic [W-1:0] p_num, p_den, s_rem, s_quo;
  logic         p_negq, p_negr, p_bad;
  logic         accept;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid & in_ready;

  div_operand_prep #(.W(W)) u_prep (
    .num(dividend), .den(divisor), .sgn(is_signed),
    .num_mag(p_num), .den_mag(p_den),
    .neg_quo(p_negq), .neg_rem(p_negr), .illegal(p_bad)
  );

  div_step #(.W(W)) u_step (
    .rem_in(part_rem), .quo_in(part_quo), .den_mag(den_q),
    .rem_out(s_rem), .quo_out(s_quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      iter_cnt  <= '0;
      part_rem  <= '0;
      part_quo  <= '0;
      den_q     <= '0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
      illegal_q <= 1'b0;
      ext_q     <= 1'b0;
      idx_q     <= '0;
      done      <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_en_r   <= 1'b0;
      ovf       <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      q_idx     <= '0;
      r_idx     <= '0;
    end else begin
      done    <= 1'b0;
      wr_en_q <= 1'b0;
      wr_en_r <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            part_rem  <= '0;
            part_quo  <= p_num;
            den_q     <= p_den;
            neg_quo_q <= p_negq;
            neg_rem_q <= p_negr;
            illegal_q <= p_bad;
            ext_q     <= ext_mode;
            idx_q     <= dst_idx;
            iter_cnt  <= '0;
            state     <= p_bad ? ST_FIX : ST_ITER;
          end
        end
        ST_ITER: begin
          part_rem <= s_rem;
          part_quo <= s_quo;
          iter_cnt <= iter_cnt + 1'b1;
          if (iter_cnt == LAST) state <= ST_FIX;
        end
        ST_FIX: begin
          done    <= 1'b1;
          ovf     <= illegal_q;
          wr_en_q <= ~illegal_q;
          wr_en_r <= ~illegal_q & ext_q;
          q_idx   <= idx_q;
          r_idx   <= idx_q + 1'b1;
          if (!illegal_q) begin
            quotient  <= neg_quo_q ? (~part_quo + 1'b1) : part_quo;
            remainder <= neg_rem_q ? (~part_rem + 1'b1) : part_rem;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/int_divider_chk.sv
module int_divider_chk #(
  parameter int W    = 32,
  parameter int IDXW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            done,
  input logic            ovf,
  input logic            wr_en_q,
  input logic            wr_en_r,
  input logic [W-1:0]    quotient,
  input logic [IDXW-1:0] q_idx,
  input logic [IDXW-1:0] r_idx
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_write_when_legal: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> (done && !ovf));

  a_r3_overflow_blocks_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> (!wr_en_q && !wr_en_r));

  a_r6_rem_pair: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_r |-> (wr_en_q && (r_idx == IDXW'(q_idx + 1'b1))));

  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !done));

  a_r11_quotient_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_q |-> $stable(quotient));

  a_r5_ovf_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ovf));
endmodule

bind int_divider int_divider_chk #(.W(W), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .ovf(ovf), .wr_en_q(wr_en_q), .wr_en_r(wr_en_r),
  .quotient(quotient), .q_idx(q_idx), .r_idx(r_idx)
);

// File: tb/int_divider_tb.sv
module int_divider_tb;
  localparam int W = 32;
  localparam int IDXW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic is_signed = 1'b0, ext_mode = 1'b0;
  logic [IDXW-1:0] dst_idx = '0;
  logic done, wr_en_q, wr_en_r, ovf;
  logic [W-1:0] quotient, remainder;
  logic [IDXW-1:0] q_idx, r_idx;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [W-1:0] last_q = '0, last_r = '0;

  always #5 clk = ~clk;

  int_divider #(.W(W), .IDXW(IDXW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dividend(dividend), .divisor(divisor), .is_signed(is_signed),
    .ext_mode(ext_mode), .dst_idx(dst_idx), .done(done),
    .quotient(quotient), .remainder(remainder), .wr_en_q(wr_en_q),
    .wr_en_r(wr_en_r), .q_idx(q_idx), .r_idx(r_idx), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_bad(input logic [W-1:0] a, b, input logic s);
    return (b == 0) || (s && b == 32'hFFFF_FFFF && a == 32'h8000_0000);
  endfunction

  function automatic logic [W-1:0] model_q(input logic [W-1:0] a, b, input logic s);
    if (s) return $signed(a) / $signed(b);
    return a / b;
  endfunction

  function automatic logic [W-1:0] model_r(input logic [W-1:0] a, b, input logic s);
    if (s) return $signed(a) % $signed(b);
    return a % b;
  endfunction

  task automatic run_op(input logic [W-1:0] a, b, input logic s, e,
                        input logic [IDXW-1:0] idx, input bit poke);
    bit ill;
    logic [W-1:0] eq, er;
    int lat;
    ill = is_bad(a, b, s);
    eq  = ill ? last_q : model_q(a, b, s);
    er  = ill ? last_r : model_r(a, b, s);
    @(negedge clk);
    chk(in_ready == 1'b1, "R7 ready idle", 64'(in_ready), 64'd1);
    dividend = a; divisor = b; is_signed = s; ext_mode = e; dst_idx = idx;
    in_valid = 1'b1;
    @(negedge clk);
    lat = 1;
    chk(in_ready == 1'b0, "R7 busy after accept", 64'(in_ready), 64'd0);
    if (poke) begin
      dividend = ~a; divisor = 32'd1; dst_idx = idx ^ 5'd1; ext_mode = ~e;
    end else begin
      in_valid = 1'b0;
    end
    while (!done && lat < W + 10) begin
      @(negedge clk);
      lat++;
      if (lat == 4) in_valid = 1'b0;
    end
    in_valid = 1'b0;
    chk(lat == (ill ? 2 : W + 2), "R9 latency", 64'(lat), 64'(ill ? 2 : W + 2));
    chk(in_ready == 1'b1, "R7 ready at done", 64'(in_ready), 64'd1);
    chk(ovf == ill, ill ? "R3 R4 ovf set" : "R5 ovf clear", 64'(ovf), 64'(ill));
    chk(wr_en_q == !ill, "R5 wr_en_q", 64'(wr_en_q), 64'(!ill));
    chk(wr_en_r == (!ill && e), "R6 wr_en_r", 64'(wr_en_r), 64'(!ill && e));
    chk(quotient == eq, s ? "R2 R11 quotient" : "R1 R11 quotient", 64'(quotient), 64'(eq));
    chk(remainder == er, s ? "R2 R11 remainder" : "R1 R11 remainder", 64'(remainder), 64'(er));
    if (!ill) begin
      chk(q_idx == idx, "R5 q_idx", 64'(q_idx), 64'(idx));
      if (e) chk(r_idx == IDXW'(idx + 1), "R6 r_idx", 64'(r_idx), 64'(IDXW'(idx + 1)));
      last_q = eq;
      last_r = er;
    end
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", 64'(done), 64'd0);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(done == 1'b0, "R8 no extra done", 64'(done), 64'd0);
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected<200000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] ra, rb;
    int sel;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready", 64'(in_ready), 64'd1);
    chk(done == 1'b0 && wr_en_q == 1'b0 && wr_en_r == 1'b0, "R10 strobes",
        {61'd0, done, wr_en_q, wr_en_r}, 64'd0);
    chk(ovf == 1'b0, "R10 ovf", 64'(ovf), 64'd0);
    chk(quotient == '0 && remainder == '0, "R10 results",
        {quotient, remainder}, 64'd0);
    rst_n = 1'b1;

    // Directed corner cases
    run_op(32'd100, 32'd7, 1'b0, 1'b1, 5'd3, 1'b0);                 // R1
    run_op(32'hFFFF_FFF9, 32'd2, 1'b1, 1'b1, 5'd4, 1'b0);           // R2 -7/2
    run_op(32'd7, 32'hFFFF_FFFE, 1'b1, 1'b1, 5'd5, 1'b0);           // R2 7/-2
    run_op(32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1, 1'b1, 5'd6, 1'b0);   // R2 -7/-2
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 5'd7, 1'b0);   // R3 R11
    run_op(32'd55, 32'd0, 1'b1, 1'b1, 5'd8, 1'b0);                  // R3
    run_op(32'd55, 32'd0, 1'b0, 1'b0, 5'd9, 1'b0);                  // R4
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1, 5'd10, 1'b0);  // R4 legal
    run_op(32'h8000_0000, 32'd1, 1'b1, 1'b0, 5'd11, 1'b0);          // R2 R6 no rem
    run_op(32'd0, 32'd5, 1'b1, 1'b1, 5'd31, 1'b0);                  // R6 wrap
    run_op(32'd1000, 32'd9, 1'b0, 1'b1, 5'd12, 1'b1);               // R8 poke

    // Constrained random
    for (int n = 0; n < 300; n++) begin
      sel = $urandom_range(0, 9);
      ra  = $urandom;
      case (sel)
        0:       rb = '0;
        1:       rb = 32'hFFFF_FFFF;
        2, 3:    rb = W'($urandom_range(1, 255));
        default: rb = $urandom;
      endcase
      if (sel == 1 && $urandom_range(0, 1) == 1) ra = 32'h8000_0000;
      run_op(ra, rb, 1'($urandom), 1'($urandom), IDXW'($urandom), (n % 50) == 7);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule